// File: doc/BRIEF.md
# Strobe-Ordered DRAM Cycle Decoder with Compressed Test Mode

This block is the device-side control of a small dynamic-memory model. It samples the active-low row strobe, column strobe, write enable and output enable on a system clock. From the order in which the strobes fall it decides what kind of cycle is running: an access (read or early write), a refresh whose row comes from an internal counter, a refresh of an explicitly addressed row, or entry into a test mode. It latches the row and column addresses, keeps the refresh row counter and drives a data bus. The bus is modelled as separate output and output-enable ports, so that a three-state pad can be placed around it. The storage is a parameterized register array of `2^(ROW_W+COL_W)` words of `DQ_W` bits.

A test mode can be latched. While it is active, the two lowest column bits stop selecting a word, and each write stores its data word into all four words of the addressed group. A read in this mode returns, for each data pin, a flag that is high when that bit holds the same value in all four words of the group. The test mode stays set across any number of ordinary cycles. Either kind of refresh cycle ends it.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset the data bus is not driven, the test mode is off, no refresh strobe is issued, and the first counter-based refresh uses row 0.
- R2: A row-strobe fall with the column strobe high latches the row from `addr`. Every column-strobe fall while that row is open latches a new column from `addr` (page mode), and the row stays the same.
- R3: A column-strobe fall with `we_n` high starts a read. Two clock edges after the strobe is presented, `dq_out` carries the addressed word and `dq_oe` is 1, provided `oe_n` is low.
- R4: `dq_oe` is 1 only while a read is active and `oe_n` is low. It drops once `oe_n` or `cas_n` has been sampled high, and it returns if `oe_n` goes low again while the read is still active.
- R5: A column-strobe fall with `we_n` low is an early write. It stores `dq_in` at the latched row and the sampled column, and `dq_oe` stays 0 for the whole cycle even with `oe_n` low.
- R6: A row-strobe fall while the column strobe is already low is a counter refresh. It gives a one-cycle `rfsh_stb` with `rfsh_row` equal to the counter, and then the counter steps by one modulo `2^ROW_W`. No data is accessed.
- R7: A row strobe that rises without any column-strobe fall since its fall gives a one-cycle `rfsh_stb`, with `rfsh_row` equal to the latched row.
- R8: A counter refresh with `we_n` low at the row-strobe fall turns the test mode on (`tm_active` = 1).
- R9: The test mode is held through read and write cycles. It is cleared by a counter refresh with `we_n` high, or by a refresh of an addressed row (R7).
- R10: In test mode a write ignores column bits 1 and 0 and stores `dq_in` into all four words whose column shares bits `COL_W-1..2`.
- R11: In test mode a read gives, on bit i of `dq_out`, 1 if bit i is equal in all four words of the addressed group and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the pad |
| dq_out | output | DQ_W | Read data toward the pad, zero when not driven |
| dq_oe | output | 1 | Pad driver enable |
| tm_active | output | 1 | Test mode latched |
| rfsh_stb | output | 1 | One-cycle pulse per refreshed row |
| rfsh_row | output | ROW_W | Row refreshed with the last pulse |

## Verification
Each strobe change is captured at one clock edge and acted on at the next, so data, `dq_oe` and `tm_active` change after the second edge that follows the change. `dq_oe` falls one edge after an output-enable rise. The bench changes its inputs at falling edges and then waits three rising edges before it samples at a falling edge, which leaves a margin of one edge beyond the latency. The refresh pulse lasts only one cycle, so a monitor counts it at every falling edge, and the checks compare the pulse count and the last row with the values the bench's own counter predicts.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
   // What the current row-strobe low period was opened for.
   typedef enum logic [1:0] {
      RK_IDLE    = 2'd0,
      RK_ACCESS  = 2'd1,
      RK_REFRESH = 2'd2
   } ras_kind_e;

   // Words sharing one test-mode group (two column bits).
   localparam int unsigned TM_GROUP = 4;
endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
   parameter int ADDR_W      = 3,
   parameter int DQ_W        = 4,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic              s_cas,
   output logic              s_we,
   output logic              s_oe,
   output logic [ADDR_W-1:0] s_addr,
   output logic [DQ_W-1:0]   s_dq,
   output logic              ras_fall,
   output logic              ras_rise,
   output logic              cas_fall,
   output logic              cas_rise
);
   localparam int VW = 4 + ADDR_W + DQ_W;
   localparam logic [VW-1:0] IDLE_V = {4'b1111, {(ADDR_W + DQ_W){1'b0}}};

   logic [VW-1:0] raw_v, st1_v, last_v;
   logic          s_ras, p_ras, p_cas;

   assign raw_v = {ras_n, cas_n, we_n, oe_n, addr, dq_in};

   always_ff @(posedge clk) begin
      if (!rst_n) st1_v <= IDLE_V;
      else        st1_v <= raw_v;
   end

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_stages
         $error("dram_strobe_sampler: SYNC_STAGES must be 1 or 2");
      end
      if (SYNC_STAGES == 2) begin : g_two
         logic [VW-1:0] st2_v;
         always_ff @(posedge clk) begin
            if (!rst_n) st2_v <= IDLE_V;
            else        st2_v <= st1_v;
         end
         assign last_v = st2_v;
      end else begin : g_one
         assign last_v = st1_v;
      end
   endgenerate

   assign s_ras  = last_v[VW-1];
   assign s_cas  = last_v[VW-2];
   assign s_we   = last_v[VW-3];
   assign s_oe   = last_v[VW-4];
   assign s_addr = last_v[DQ_W +: ADDR_W];
   assign s_dq   = last_v[DQ_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_ras <= 1'b1;
         p_cas <= 1'b1;
      end else begin
         p_ras <= s_ras;
         p_cas <= s_cas;
      end
   end

   assign ras_fall = p_ras & ~s_ras;
   assign ras_rise = ~p_ras & s_ras;
   assign cas_fall = p_cas & ~s_cas;
   assign cas_rise = ~p_cas & s_cas;
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
   import dram_dec_pkg::*;
#(
   parameter int ROW_W  = 3,
   parameter int COL_W  = 3,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_cas,
   input  logic              s_we,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic              ras_fall,
   input  logic              ras_rise,
   input  logic              cas_fall,
   input  logic              cas_rise,
   output logic [ROW_W-1:0]  row_q,
   output logic [COL_W-1:0]  col_q,
   output logic              wr_en,
   output logic [COL_W-1:0]  wr_col,
   output logic              rd_active,
   output logic              tm_active,
   output logic              rfsh_stb,
   output logic [ROW_W-1:0]  rfsh_row
);
   ras_kind_e        kind_q;
   logic             cas_seen_q;
   logic             rd_q, tm_q, stb_q;
   logic [ROW_W-1:0] rcnt_q, rrow_q;
   logic             open_row;

   assign open_row = (kind_q == RK_ACCESS);
   assign wr_en    = cas_fall & open_row & ~s_we;
   assign wr_col   = s_addr[COL_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q     <= RK_IDLE;
         cas_seen_q <= 1'b0;
         rd_q       <= 1'b0;
         tm_q       <= 1'b0;
         stb_q      <= 1'b0;
         rcnt_q     <= '0;
         rrow_q     <= '0;
         row_q      <= '0;
         col_q      <= '0;
      end else begin
         stb_q <= 1'b0;
         if (ras_fall) begin
            if (!s_cas) begin
               // column strobe already low: counter refresh, maybe test entry
               kind_q <= RK_REFRESH;
               stb_q  <= 1'b1;
               rrow_q <= rcnt_q;
               rcnt_q <= rcnt_q + 1'b1;
               tm_q   <= ~s_we;
            end else begin
               kind_q     <= RK_ACCESS;
               row_q      <= s_addr[ROW_W-1:0];
               cas_seen_q <= 1'b0;
            end
         end else if (ras_rise) begin
            if (open_row && !cas_seen_q && !cas_fall) begin
               // no column access happened: addressed-row refresh
               stb_q  <= 1'b1;
               rrow_q <= row_q;
               tm_q   <= 1'b0;
            end
            kind_q <= RK_IDLE;
         end

         if (cas_fall && open_row) begin
            cas_seen_q <= 1'b1;
            col_q      <= s_addr[COL_W-1:0];
            rd_q       <= s_we;
         end else if (cas_rise) begin
            rd_q <= 1'b0;
         end
      end
   end

   assign rd_active = rd_q;
   assign tm_active = tm_q;
   assign rfsh_stb  = stb_q;
   assign rfsh_row  = rrow_q;

   assert_cbr_uses_counter_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !s_cas) |=> (rfsh_stb && rfsh_row == $past(rcnt_q)
                                && rcnt_q == $past(rcnt_q) + 1'b1));
   assert_test_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !s_cas && !s_we) |=> tm_active);
   assert_test_clear_cbr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !s_cas && s_we) |=> !tm_active);
   assert_test_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_fall && !ras_rise) |=> $stable(tm_active));
   assert_write_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rd_active);
   assert_refresh_not_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !s_cas) |=> (kind_q == RK_REFRESH));
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array
   import dram_dec_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3,
   parameter int DQ_W  = 4
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [COL_W-1:0] wr_col,
   input  logic [DQ_W-1:0]  wdata,
   input  logic [ROW_W-1:0] rd_row,
   input  logic [COL_W-1:0] rd_col,
   input  logic             tm,
   output logic [DQ_W-1:0]  rdata
);
   localparam int AW    = ROW_W + COL_W;
   localparam int DEPTH = 1 << AW;

   generate
      if (COL_W < 2) begin : g_bad_col
         $error("dram_cell_array: COL_W must be at least 2 for test groups");
      end
   endgenerate

   logic [DQ_W-1:0] mem [DEPTH];
   logic [DQ_W-1:0] grp [TM_GROUP];
   logic [DQ_W-1:0] plain, cmp;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (tm) begin
            for (int j = 0; j < TM_GROUP; j++)
               mem[{wr_row, wr_col[COL_W-1:2], 2'(j)}] <= wdata;
         end else begin
            mem[{wr_row, wr_col}] <= wdata;
         end
      end
   end

   assign plain = mem[{rd_row, rd_col}];

   genvar g, b;
   generate
      for (g = 0; g < TM_GROUP; g++) begin : g_grp
         assign grp[g] = mem[{rd_row, rd_col[COL_W-1:2], 2'(g)}];
      end
      for (b = 0; b < DQ_W; b++) begin : g_cmp
         logic [TM_GROUP-1:0] bits;
         assign bits   = {grp[3][b], grp[2][b], grp[1][b], grp[0][b]};
         assign cmp[b] = (&bits) | ~(|bits);
      end
   endgenerate

   assign rdata = tm ? cmp : plain;
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
   parameter int ROW_W       = 3,
   parameter int COL_W       = 3,
   parameter int DQ_W        = 4,
   parameter int SYNC_STAGES = 1,
   localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic              tm_active,
   output logic              rfsh_stb,
   output logic [ROW_W-1:0]  rfsh_row
);
   logic              s_cas, s_we, s_oe;
   logic [ADDR_W-1:0] s_addr;
   logic [DQ_W-1:0]   s_dq, rdata;
   logic              ras_fall, ras_rise, cas_fall, cas_rise;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q, wr_col;
   logic              wr_en, rd_active;

   dram_strobe_sampler #(
      .ADDR_W(ADDR_W), .DQ_W(DQ_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_smp (
      .clk(clk), .rst_n(rst_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_in(dq_in),
      .s_cas(s_cas), .s_we(s_we), .s_oe(s_oe), .s_addr(s_addr), .s_dq(s_dq),
      .ras_fall(ras_fall), .ras_rise(ras_rise),
      .cas_fall(cas_fall), .cas_rise(cas_rise)
   );

   dram_cycle_ctrl #(
      .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .s_cas(s_cas), .s_we(s_we), .s_addr(s_addr),
      .ras_fall(ras_fall), .ras_rise(ras_rise),
      .cas_fall(cas_fall), .cas_rise(cas_rise),
      .row_q(row_q), .col_q(col_q), .wr_en(wr_en), .wr_col(wr_col),
      .rd_active(rd_active), .tm_active(tm_active),
      .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
   );

   dram_cell_array #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)
   ) u_arr (
      .clk(clk), .wr_en(wr_en), .wr_row(row_q), .wr_col(wr_col), .wdata(s_dq),
      .rd_row(row_q), .rd_col(col_q), .tm(tm_active), .rdata(rdata)
   );

   assign dq_oe  = rd_active & ~s_oe;
   assign dq_out = dq_oe ? rdata : '0;

   assert_read_ends_on_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_cas) |=> !dq_oe);
   assert_oe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_oe) |-> !dq_oe);
   assert_one_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, cas_fall && rd_active === 1'b0 && !s_we && 1'b0, rfsh_stb && wr_en}));
endmodule

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;
   localparam int CLK_NS = 10;
   localparam int ROW_W  = 3;
   localparam int COL_W  = 3;
   localparam int DQ_W   = 4;
   localparam int ROWS   = 1 << ROW_W;
   localparam int COLS   = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [2:0]       addr = '0;
   logic [DQ_W-1:0]  dq_in = '0;
   logic [DQ_W-1:0]  dq_out;
   logic             dq_oe, tm_active, rfsh_stb;
   logic [ROW_W-1:0] rfsh_row;

   dram_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .tm_active(tm_active), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
   );

   always #(CLK_NS / 2) clk = ~clk;

   int n_checks = 0, n_errors = 0;
   logic [DQ_W-1:0] ref_mem [ROWS*COLS];
   bit  ref_tm = 1'b0;
   int  ref_cnt = 0;
   int  stb_seen = 0, stb_row = -1;

   always @(negedge clk) begin
      if (rst_n && rfsh_stb) begin
         stb_seen++;
         stb_row = int'(rfsh_row);
      end
   end

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [DQ_W-1:0] exp_read(int r, int c);
      logic [DQ_W-1:0] res;
      int base;
      if (!ref_tm) return ref_mem[r*COLS + c];
      base = r*COLS + (c / 4) * 4;
      for (int b = 0; b < DQ_W; b++) begin
         int ones = 0;
         for (int j = 0; j < 4; j++) ones += int'(ref_mem[base + j][b]);
         res[b] = (ones == 0 || ones == 4);
      end
      return res;
   endfunction

   task automatic wr_cyc(int r, int c, logic [DQ_W-1:0] d);
      addr = 3'(r); ras_n = 1'b0; settle();
      addr = 3'(c); dq_in = d; we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0; settle();
      chk("R5 early write keeps bus off", dq_oe, 0);
      cas_n = 1'b1; settle();
      chk("R5 bus off after write", dq_oe, 0);
      we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; settle();
      if (ref_tm) for (int j = 0; j < 4; j++) ref_mem[r*COLS + (c/4)*4 + j] = d;
      else        ref_mem[r*COLS + c] = d;
   endtask

   task automatic rd_cyc(int r, int c, string tag);
      addr = 3'(r); ras_n = 1'b0; settle();
      addr = 3'(c); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; settle();
      chk({tag, " bus driven"}, dq_oe, 1);
      chk({tag, " read data"}, dq_out, exp_read(r, c));
      oe_n = 1'b1; settle();
      chk("R4 oe high releases bus", dq_oe, 0);
      oe_n = 1'b0; settle();
      chk("R4 oe low again drives", dq_oe, 1);
      cas_n = 1'b1; settle();
      chk("R4 cas high releases bus", dq_oe, 0);
      ras_n = 1'b1; oe_n = 1'b1; settle();
   endtask

   task automatic cbr_cyc(logic w);
      we_n = w; cas_n = 1'b0; settle();
      ras_n = 1'b0; settle();
      ras_n = 1'b1; settle();
      cas_n = 1'b1; we_n = 1'b1; settle();
      ref_tm = !w;
      ref_cnt = (ref_cnt + 1) % ROWS;
   endtask

   task automatic ras_only(int r);
      addr = 3'(r); ras_n = 1'b0; settle();
      ras_n = 1'b1; settle();
      ref_tm = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int s0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1 reset state
      chk("R1 bus off after reset", dq_oe, 0);
      chk("R1 test mode off after reset", tm_active, 0);
      chk("R1 no refresh strobe after reset", stb_seen, 0);

      // R6 counter refresh sequence, wrapping once; first row is 0 (R1)
      for (int k = 0; k <= ROWS; k++) begin
         s0 = ref_cnt;
         cbr_cyc(1'b1);
         chk("R6 one strobe per counter refresh", stb_seen, k + 1);
         chk("R6 counter refresh row", stb_row, s0);
      end

      // R2 R3 R5 full write then read sweep
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            wr_cyc(r, c, DQ_W'((r*5 + c*3 + 1) % 16));
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            rd_cyc(r, c, "R3");

      // R2 page mode: one row open, several columns
      addr = 3'd4; ras_n = 1'b0; settle();
      for (int c = 7; c >= 0; c -= 3) begin
         addr = 3'(c); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; settle();
         chk("R2 page mode column data", dq_out, ref_mem[4*COLS + c]);
         cas_n = 1'b1; addr = 3'd0; settle();
      end
      ras_n = 1'b1; oe_n = 1'b1; settle();

      // R7 addressed-row refresh
      s0 = stb_seen;
      ras_only(5);
      chk("R7 strobe for addressed refresh", stb_seen, s0 + 1);
      chk("R7 addressed refresh row", stb_row, 5);

      // R8 test mode entry (also a counter refresh, R6)
      s0 = ref_cnt;
      cbr_cyc(1'b0);
      chk("R8 test mode entered", tm_active, 1);
      chk("R6 counter row at test entry", stb_row, s0);

      // R11 compressed reads over every row and group; R9 held
      for (int r = 0; r < ROWS; r++)
         for (int g = 0; g < COLS / 4; g++)
            rd_cyc(r, g*4 + (r % 4), "R11");
      chk("R9 test mode held over reads", tm_active, 1);

      // R10 broadcast write, then compressed read of the same group
      wr_cyc(1, 5, 4'hA);
      chk("R9 test mode held over write", tm_active, 1);
      rd_cyc(1, 6, "R11 equal group");

      // R9 exit through addressed refresh, R10 check of each word
      ras_only(3);
      chk("R9 addressed refresh clears test mode", tm_active, 0);
      for (int c = 4; c < 8; c++) rd_cyc(1, c, "R10 broadcast word");

      // R11 unequal group
      wr_cyc(1, 6, 4'h3);
      cbr_cyc(1'b0);
      chk("R8 test mode re-entered", tm_active, 1);
      rd_cyc(1, 4, "R11 unequal group");
      chk("R11 unequal group flags", exp_read(1, 4), 6);

      // R9 exit through plain counter refresh
      cbr_cyc(1'b1);
      chk("R9 counter refresh clears test mode", tm_active, 0);
      rd_cyc(1, 6, "R3 normal after exit");
      rd_cyc(1, 7, "R3 normal after exit");

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule